// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake

This block is a watchdog that keeps running on its own low-power clock, so a halted or failed processor clock cannot stop it. A counter in the watchdog clock domain advances on every watchdog clock edge while the watchdog is enabled. When the counter reaches its terminal count, the block raises a timeout. If the processor is awake, the timeout becomes a device reset request. If the processor is asleep, the timeout becomes a wake request. The processor keeps the watchdog quiet by pulsing a clear strobe often enough.

Whether the watchdog may run is decided by a fixed configuration input. When that input is high, the watchdog runs whatever software does. When it is low, a software-written enable bit turns the watchdog on and off. A sticky status flag in the processor clock domain records that a timeout occurred, so that boot code can tell a watchdog reset or wake apart from other causes. Software clears the flag with a one-cycle strobe.

The enable level, the stretched clear level and the sleep level cross into the watchdog domain through register synchronisers. Each timeout returns to the processor domain as a toggle.

Top module: `wdog_sleep_wake`

## Requirements
- R1: While `rst` and `wrst` are asserted, and on the first cycle after both are released, `reset_req`, `wake_req` and `timeout_flag` are 0. The software enable bit resets to 0.
- R2: While `cfg_force_en` is 1, the watchdog is enabled. Writing 0 to the software enable bit does not stop the timeouts.
- R3: While `cfg_force_en` is 0, the software enable bit alone decides. Software writes the bit with `sw_en_we`=1 and the value on `sw_en_wdata`. While the bit is 0, no timeout occurs and the count is held at zero.
- R4: While the watchdog is enabled and no clear arrives, timeouts repeat exactly every TERM+1 watchdog clock cycles. The count runs from 0 to TERM and then restarts at 0.
- R5: A timeout while `sleep_mode` is 0 drives `reset_req` to 1 for exactly one watchdog clock cycle. `wake_req` stays 0.
- R6: A timeout while `sleep_mode` is 1 drives `wake_req` to 1 for exactly one watchdog clock cycle. `reset_req` stays 0. The two requests are never high together.
- R7: A one-cycle `clr_strobe` raises a clear level for CLR_HOLD processor clock cycles. The counter is held at zero while the synchronised clear level is high. Strobes spaced more closely than the timeout period prevent every timeout.
- R8: After each timeout, `timeout_flag` goes to 1 in the processor clock domain. It stays 1 until a one-cycle `flag_clr`. A timeout that arrives in the same cycle as `flag_clr` wins.
- R9: Timing, counted in clock edges:
  - The enable level is registered on `clk` one cycle after `cfg_force_en` or the enable bit changes.
  - The enable, clear and `sleep_mode` levels are acted on at the second `wclk` edge after the edge that first samples them.
  - `reset_req` and `wake_req` are registered at the `wclk` edge where the timeout happens.
  - `timeout_flag` sets on the third `clk` edge after the timeout edge.
- R10: With `clk` stopped, the counter keeps counting on `wclk` and keeps issuing reset requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset, processor domain |
| wclk | input | 1 | Low-power watchdog clock |
| wrst | input | 1 | Synchronous active-high power-on reset, watchdog domain |
| cfg_force_en | input | 1 | Fixed configuration: 1 forces the watchdog on, 0 hands control to software |
| sw_en_we | input | 1 | Write strobe for the software enable bit |
| sw_en_wdata | input | 1 | Value written to the software enable bit |
| clr_strobe | input | 1 | One-cycle watchdog clear from the processor |
| sleep_mode | input | 1 | 1 while the processor is asleep |
| flag_clr | input | 1 | One-cycle clear of the timeout status flag |
| reset_req | output | 1 | One-`wclk`-cycle device reset request |
| wake_req | output | 1 | One-`wclk`-cycle wake request |
| timeout_flag | output | 1 | Sticky timeout status, processor domain |

## Verification
The bench runs a model of the block, built from the requirements, on both clocks. It compares the two requests on every watchdog cycle and the flag on every processor cycle. The stimulus moves through a sequence of input patterns:
- With every enable source low, the run shows that nothing counts.
- With software enable alone, it measures the timeout spacing and tells a correct period from an off-by-one.
- With the configuration input forcing the watchdog on while software writes 0, it separates the OR of the two sources from software-only control.
- With `sleep_mode` high, it tells the wake path from the reset path.
- With clear strobes repeated faster than the period, it shows that a clear holds off the timeout.
- A flag clear followed by a fresh timeout checks that the flag is sticky.
- With the processor clock halted, it shows that the watchdog still resets the device when the main clock is lost.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Levels carried from the processor domain into the watchdog domain
    typedef struct packed {
        logic en;   // watchdog allowed to count
        logic clr;  // stretched clear level
        logic slp;  // processor asleep
    } wd_ctl_t;

    localparam int WD_CTL_W = $bits(wd_ctl_t);

    typedef enum logic [1:0] {
        WD_EV_NONE  = 2'd0,
        WD_EV_RESET = 2'd1,
        WD_EV_WAKE  = 2'd2
    } wd_evt_e;

    // Choose the kind of request a terminal-count hit turns into
    function automatic wd_evt_e wd_classify(input logic hit, input logic asleep);
        if (!hit) begin
            return WD_EV_NONE;
        end
        return asleep ? WD_EV_WAKE : WD_EV_RESET;
    endfunction
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [STAGES-1:0][W-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/wdt_host_side.sv
module wdt_host_side #(
    parameter int CLR_HOLD    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_force_en,
    input  logic sw_en_we,
    input  logic sw_en_wdata,
    input  logic clr_strobe,
    input  logic flag_clr,
    input  logic to_tgl_w,
    output logic en_q,
    output logic clr_lvl,
    output logic timeout_flag
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HOLD_W = $clog2(CLR_HOLD + 1);

    logic              sw_en_q;
    logic [HOLD_W-1:0] hold_q;
    logic              tgl_s;
    logic              tgl_prev;
    logic              to_seen;

    // Software enable bit and combined enable level
    always_ff @(posedge clk) begin
        if (rst) begin
            sw_en_q <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            en_q <= cfg_force_en | sw_en_q;
            if (sw_en_we) begin
                sw_en_q <= sw_en_wdata;
            end
        end
    end

    // Clear stretcher: a strobe holds the level for CLR_HOLD cycles
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            clr_lvl <= 1'b0;
        end else if (clr_strobe) begin
            hold_q  <= HOLD_W'(CLR_HOLD - 1);
            clr_lvl <= 1'b1;
        end else if (hold_q != '0) begin
            hold_q  <= hold_q - HOLD_W'(1);
            clr_lvl <= 1'b1;
        end else begin
            clr_lvl <= 1'b0;
        end
    end

    // Timeout toggle returning from the watchdog domain
    wdt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tgl_sync (
        .clk (clk),
        .rst (rst),
        .d   (to_tgl_w),
        .q   (tgl_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_prev <= 1'b0;
        end else begin
            tgl_prev <= tgl_s;
        end
    end

    assign to_seen = tgl_s ^ tgl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            timeout_flag <= 1'b0;
        end else if (to_seen) begin
            timeout_flag <= 1'b1;
        end else if (flag_clr) begin
            timeout_flag <= 1'b0;
        end
    end

    // R2: forcing configuration always yields an enabled level
    p_force_on_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_force_en |=> en_q);

    // R7: a strobe always raises the clear level on the next cycle
    p_clr_raise_r7: assert property (@(posedge clk) disable iff (rst)
        clr_strobe |=> clr_lvl);

    // R8: the flag is sticky until software clears it
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag && !flag_clr) |=> timeout_flag);
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core
    import wdt_pkg::*;
#(
    parameter int          CNT_W = 16,
    parameter int unsigned TERM  = 65535
) (
    input  logic    wclk,
    input  logic    wrst,
    input  wd_ctl_t ctl,
    output logic    reset_req,
    output logic    wake_req,
    output logic    to_tgl
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [CNT_W-1:0] TERM_C = CNT_W'(TERM);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic             hit;
    wd_evt_e          evt;

    always_comb begin
        hit = ctl.en && !ctl.clr && (cnt == TERM_C);
        if (!ctl.en || ctl.clr || hit) begin
            cnt_nx = '0;
        end else begin
            cnt_nx = cnt + CNT_W'(1);
        end
        evt = wd_classify(hit, ctl.slp);
    end

    always_ff @(posedge wclk) begin
        if (wrst) begin
            cnt       <= '0;
            reset_req <= 1'b0;
            wake_req  <= 1'b0;
            to_tgl    <= 1'b0;
        end else begin
            cnt       <= cnt_nx;
            reset_req <= (evt == WD_EV_RESET);
            wake_req  <= (evt == WD_EV_WAKE);
            to_tgl    <= to_tgl ^ (evt != WD_EV_NONE);
        end
    end

    // R4: the count never passes the terminal value
    p_cnt_bound_r4: assert property (@(posedge wclk) disable iff (wrst)
        cnt <= TERM_C);

    // R4: an enabled, uncleared count below terminal advances by one
    p_cnt_step_r4: assert property (@(posedge wclk) disable iff (wrst)
        (ctl.en && !ctl.clr && cnt != TERM_C) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R3: a disabled watchdog holds its count at zero
    p_off_zero_r3: assert property (@(posedge wclk) disable iff (wrst)
        !ctl.en |=> (cnt == '0));

    // R7: a seen clear level restarts the count
    p_clr_zero_r7: assert property (@(posedge wclk) disable iff (wrst)
        ctl.clr |=> (cnt == '0));

    // R5: reset request lasts a single watchdog cycle
    p_rst_pulse_r5: assert property (@(posedge wclk) disable iff (wrst)
        reset_req |=> !reset_req);

    // R6: wake request lasts a single cycle and never pairs with reset
    p_wake_pulse_r6: assert property (@(posedge wclk) disable iff (wrst)
        wake_req |=> !wake_req);

    p_req_excl_r6: assert property (@(posedge wclk) disable iff (wrst)
        !(reset_req && wake_req));
endmodule

// File: rtl/wdog_sleep_wake.sv
module wdog_sleep_wake
    import wdt_pkg::*;
#(
    parameter int          CNT_W       = 16,
    parameter int unsigned TERM        = 65535,
    parameter int          CLR_HOLD    = 4,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wclk,
    input  logic wrst,
    input  logic cfg_force_en,
    input  logic sw_en_we,
    input  logic sw_en_wdata,
    input  logic clr_strobe,
    input  logic sleep_mode,
    input  logic flag_clr,
    output logic reset_req,
    output logic wake_req,
    output logic timeout_flag
);
    timeunit 1ns;
    timeprecision 1ps;

    logic    en_q;
    logic    clr_lvl;
    logic    to_tgl;
    wd_ctl_t ctl_h;
    wd_ctl_t ctl_w;

    wdt_host_side #(
        .CLR_HOLD    (CLR_HOLD),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_host (
        .clk          (clk),
        .rst          (rst),
        .cfg_force_en (cfg_force_en),
        .sw_en_we     (sw_en_we),
        .sw_en_wdata  (sw_en_wdata),
        .clr_strobe   (clr_strobe),
        .flag_clr     (flag_clr),
        .to_tgl_w     (to_tgl),
        .en_q         (en_q),
        .clr_lvl      (clr_lvl),
        .timeout_flag (timeout_flag)
    );

    assign ctl_h = '{en: en_q, clr: clr_lvl, slp: sleep_mode};

    wdt_sync #(.W(WD_CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk (wclk),
        .rst (wrst),
        .d   (ctl_h),
        .q   (ctl_w)
    );

    wdt_count_core #(
        .CNT_W (CNT_W),
        .TERM  (TERM)
    ) u_core (
        .wclk      (wclk),
        .wrst      (wrst),
        .ctl       (ctl_w),
        .reset_req (reset_req),
        .wake_req  (wake_req),
        .to_tgl    (to_tgl)
    );
endmodule

// File: tb/wdog_sleep_wake_tb_top.sv
module wdog_sleep_wake_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TERM = 20;
    localparam int HOLD = 4;

    logic clk  = 1'b0;
    logic wclk = 1'b0;
    logic rst  = 1'b1;
    logic wrst = 1'b1;
    bit   clk_run = 1'b1;

    logic cfg_force_en = 1'b0;
    logic sw_en_we     = 1'b0;
    logic sw_en_wdata  = 1'b0;
    logic clr_strobe   = 1'b0;
    logic sleep_mode   = 1'b0;
    logic flag_clr     = 1'b0;
    logic reset_req, wake_req, timeout_flag;

    int checks = 0;
    int errors = 0;

    wdog_sleep_wake #(.CNT_W(16), .TERM(TERM), .CLR_HOLD(HOLD), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .wclk(wclk), .wrst(wrst),
        .cfg_force_en(cfg_force_en), .sw_en_we(sw_en_we), .sw_en_wdata(sw_en_wdata),
        .clr_strobe(clr_strobe), .sleep_mode(sleep_mode), .flag_clr(flag_clr),
        .reset_req(reset_req), .wake_req(wake_req), .timeout_flag(timeout_flag)
    );

    // 125 MHz processor clock (stoppable); watchdog clock of 24 ns period, edges off the clk grid
    initial forever begin
        #4;
        if (clk_run) clk = ~clk;
    end
    initial forever begin
        #6 wclk = 1'b1;
        #12 wclk = 1'b0;
        #6;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_swen, m_en, m_hold, m_lvl, m_flag, h0, h1, h2;
    int qe0, qe1, qc0, qc1, qs0, qs1, cnt, e_rst, e_wake, m_tgl;

    always @(posedge clk) begin
        if (rst) begin
            m_swen = 0; m_en = 0; m_hold = 0; m_lvl = 0; m_flag = 0;
            h0 = 0; h1 = 0; h2 = 0;
        end else begin
            int ev;
            ev = h1 ^ h2;
            h2 = h1; h1 = h0; h0 = m_tgl;
            if (ev != 0) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            m_en = (cfg_force_en || m_swen != 0) ? 1 : 0;
            if (sw_en_we) m_swen = sw_en_wdata;
            if (clr_strobe) begin
                m_hold = HOLD - 1; m_lvl = 1;
            end else if (m_hold > 0) begin
                m_hold--; m_lvl = 1;
            end else begin
                m_lvl = 0;
            end
        end
    end

    always @(posedge wclk) begin
        if (wrst) begin
            qe0 = 0; qe1 = 0; qc0 = 0; qc1 = 0; qs0 = 0; qs1 = 0;
            cnt = 0; e_rst = 0; e_wake = 0; m_tgl = 0;
        end else begin
            int ue, uc, us, hit;
            ue = qe1; uc = qc1; us = qs1;
            qe1 = qe0; qc1 = qc0; qs1 = qs0;
            qe0 = m_en; qc0 = m_lvl; qs0 = sleep_mode;
            hit = (ue != 0 && uc == 0 && cnt == TERM) ? 1 : 0;
            if (ue == 0 || uc != 0 || hit != 0) cnt = 0;
            else cnt++;
            e_rst  = (hit != 0 && us == 0) ? 1 : 0;
            e_wake = (hit != 0 && us != 0) ? 1 : 0;
            if (hit != 0) m_tgl = m_tgl ^ 1;
        end
    end

    // ---------------- per-cycle comparison and event counting ----------------
    int  n_rst = 0, n_wake = 0, wcyc = 0, last_rst = -1;
    bit  meas = 1'b0;

    always @(negedge wclk) begin
        check("R9 R5", "reset_req vs model", reset_req, e_rst);
        check("R9 R6", "wake_req vs model", wake_req, e_wake);
        if (!wrst) begin
            if (reset_req) begin
                n_rst++;
                if (meas && last_rst >= 0) check("R4", "timeout spacing", wcyc - last_rst, TERM + 1);
                last_rst = wcyc;
            end
            if (wake_req) n_wake++;
            wcyc++;
        end
    end

    always @(negedge clk) begin
        check("R8", "timeout_flag vs model", timeout_flag, m_flag);
    end

    task automatic wait_w(input int n);
        repeat (n) @(negedge wclk);
    endtask

    task automatic zero_counts();
        n_rst = 0;
        n_wake = 0;
    endtask

    task automatic write_sw(input logic v);
        @(negedge clk);
        sw_en_we = 1'b1; sw_en_wdata = v;
        @(negedge clk);
        sw_en_we = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr_strobe = 1'b1;
        @(negedge clk);
        clr_strobe = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1600000;
        checks++;
        errors++;
        $display("FAIL watchdog R1 run did not complete actual=running expected=done");
        finish_run();
    end

    initial begin
        wait_w(5);
        rst = 1'b0;
        wrst = 1'b0;
        @(negedge clk);
        check("R1", "reset_req after reset", reset_req, 0);
        check("R1", "wake_req after reset", wake_req, 0);
        check("R1", "timeout_flag after reset", timeout_flag, 0);

        // R3: all enable sources low
        zero_counts();
        wait_w(60);
        check("R3", "reset pulses while disabled", n_rst, 0);
        check("R3", "flag while disabled", timeout_flag, 0);

        // R3/R4/R5: software enable only
        write_sw(1'b1);
        wait_w(5);
        zero_counts();
        last_rst = -1;
        meas = 1'b1;
        wait_w(100);
        meas = 1'b0;
        check("R5", "reset pulses with software enable", (n_rst >= 4) ? 1 : 0, 1);
        check("R5", "no wake while awake", n_wake, 0);

        // R2: configuration forces on, software writes 0
        cfg_force_en = 1'b1;
        wait_w(2);
        write_sw(1'b0);
        wait_w(4);
        zero_counts();
        wait_w(84);
        check("R2", "reset pulses with forced enable", (n_rst >= 4) ? 1 : 0, 1);

        // R6: timeouts while asleep
        sleep_mode = 1'b1;
        wait_w(4);
        zero_counts();
        wait_w(84);
        check("R6", "wake pulses while asleep", (n_wake >= 4) ? 1 : 0, 1);
        check("R6", "reset pulses while asleep", n_rst, 0);
        sleep_mode = 1'b0;

        // R7: clears more often than the period
        pulse_clr();
        wait_w(4);
        zero_counts();
        for (int i = 0; i < 10; i++) begin
            wait_w(10);
            pulse_clr();
        end
        check("R7", "reset pulses under clear", n_rst, 0);
        check("R7", "wake pulses under clear", n_wake, 0);

        // R8: flag sticky, software clear, then set again
        check("R8", "flag held from earlier timeouts", timeout_flag, 1);
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R8", "flag after clear", timeout_flag, 0);
        zero_counts();
        wait_w(30);
        check("R8", "flag set by new timeout", timeout_flag, 1);
        check("R5", "new timeout after clears stop", (n_rst >= 1) ? 1 : 0, 1);

        // R10: processor clock halted
        @(negedge clk);
        clk_run = 1'b0;
        zero_counts();
        wait_w(60);
        check("R10", "reset pulses with clk stopped", (n_rst >= 2) ? 1 : 0, 1);
        clk_run = 1'b1;
        wait_w(10);
        check("R10", "flag after clk resumes", timeout_flag, 1);

        finish_run();
    end
endmodule